// File: doc/BRIEF.md
# Completion Interrupt Coalescer with Timeout

This block decides when a descriptor-processing engine tells the host that work has finished. It watches the number of completed descriptors that software has not yet retired. Once that number reaches a programmed threshold, it issues a single posted message write. It also issues one when a programmable inactivity timer runs out while work is pending. The message carries a 48-bit target address, built from a 32-bit low word and a 16-bit high word, and a 32-bit payload. It leaves the block on a request/acknowledge port.

Software sets the threshold, the timer enable, the timeout and the message fields through a small word-addressed write/read bus. The ring tracker supplies the live pending count and a one-cycle pulse for each new completion.

Only one message is in flight at a time. After it is acknowledged, the block stays quiet until the pending count moves away from the value it had at the acknowledge. This stops a static backlog from flooding the host.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset the control word at offset 0x00 reads 0x0000_0014 (threshold 20, timer off), the timeout word at offset 0x04 reads 0x0000_00B0, and msg_req_o is low.
- R2: Control word bits [14:0] hold the count threshold and bit 18 enables the timer; all other control bits read 0. The timeout at 0x04 keeps bits [12:0]. The address high word at 0x0C keeps bits [15:0]. The address low word at 0x08 and the payload at 0x10 keep all 32 bits.
- R3: With a nonzero threshold and the block armed, a pending count at or above the threshold raises msg_req_o at the next clock edge.
- R4: A threshold of zero never raises a message through the count path, whatever the pending count.
- R5: With the timer enabled and timeout T, the timer restarts in any cycle where the pending count is zero, done_i is high, or a message is issued. The timer counts one per cycle otherwise. A message is raised at the edge after it has counted T cycles, so msg_req_o rises T+1 edges after the restart cycle.
- R6: With the timer disabled, no message is raised by elapsed time.
- R7: With zero pending, no message is raised, even with the timer enabled and a timeout of 0.
- R8: While msg_req_o is high, msg_addr_o = {high[15:0], low[31:0]} and msg_data_o are the values captured when the request rose. They stay stable, even if the registers are rewritten, until msg_ack_i.
- R9: msg_req_o drops the edge after msg_ack_i. After that, no new message is raised until the pending count differs from its value at the acknowledge. Rearming takes one cycle.
- R10: A count hit and a timeout expiry in the same cycle produce exactly one message.
- R11: A done_i pulse restarts the inactivity timer without raising a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| pend_cnt_i | input | 15 | Completed descriptors pending |
| done_i | input | 1 | One-cycle pulse per completion |
| msg_req_o | output | 1 | Message write request |
| msg_ack_i | input | 1 | Message write accepted |
| msg_addr_o | output | 48 | Message target address |
| msg_data_o | output | 32 | Message payload |

## Verification
The count path is tried with pending values just below, at and above several thresholds, including 1, the 15-bit maximum and zero. This separates `>=` from `>` and from a dead zero threshold. The timer path is timed edge by edge after a zero-to-nonzero step and after a done_i pulse, which exposes an off-by-one count and a missing restart. A timeout of 0 with zero pending shows whether the pending gate is present. A threshold hit landing on the same edge as expiry, followed by a static count after the acknowledge, shows both duplicate firing and faulty rearming.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int THR_W      = 15;
  localparam int TMO_W      = 13;
  localparam int AHI_W      = 16;
  localparam int DW         = 32;
  localparam int AW         = 5;
  localparam int TMR_EN_BIT = 18;
  localparam int MA_W       = DW + AHI_W;

  typedef enum logic [AW-1:0] {
    OFS_CTRL = 5'h00,
    OFS_TMO  = 5'h04,
    OFS_ALO  = 5'h08,
    OFS_AHI  = 5'h0C,
    OFS_DATA = 5'h10
  } reg_ofs_e;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic             tmr_en;
    logic [TMO_W-1:0] tmo;
    logic [DW-1:0]    alo;
    logic [AHI_W-1:0] ahi;
    logic [DW-1:0]    data;
  } cfg_t;

  typedef enum logic {ST_IDLE, ST_REQ} trig_st_e;
endpackage

// File: rtl/cic_regs.sv
module cic_regs
  import cic_pkg::*;
#(
  parameter int unsigned DEF_THR    = 20,
  parameter int unsigned DEF_TMO    = 176,
  parameter bit          DEF_TMR_EN = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output cfg_t          cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.thr    <= THR_W'(DEF_THR);
      cfg_q.tmr_en <= DEF_TMR_EN;
      cfg_q.tmo    <= TMO_W'(DEF_TMO);
      cfg_q.alo    <= '0;
      cfg_q.ahi    <= '0;
      cfg_q.data   <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_CTRL: begin
          cfg_q.thr    <= wdata_i[THR_W-1:0];
          cfg_q.tmr_en <= wdata_i[TMR_EN_BIT];
        end
        OFS_TMO:  cfg_q.tmo  <= wdata_i[TMO_W-1:0];
        OFS_ALO:  cfg_q.alo  <= wdata_i;
        OFS_AHI:  cfg_q.ahi  <= wdata_i[AHI_W-1:0];
        OFS_DATA: cfg_q.data <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFS_CTRL: begin
        rdata_o[THR_W-1:0]  = cfg_q.thr;
        rdata_o[TMR_EN_BIT] = cfg_q.tmr_en;
      end
      OFS_TMO:  rdata_o[TMO_W-1:0] = cfg_q.tmo;
      OFS_ALO:  rdata_o = cfg_q.alo;
      OFS_AHI:  rdata_o[AHI_W-1:0] = cfg_q.ahi;
      OFS_DATA: rdata_o = cfg_q.data;
      default:  rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cic_timer.sv
module cic_timer
  import cic_pkg::*;
#(
  parameter int unsigned PRESCALE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             expired_o
);
  logic             tick;
  logic [TMO_W-1:0] cnt_q;

  generate
    if (PRESCALE > 1) begin : g_div
      localparam int PW = $clog2(PRESCALE);
      logic [PW-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        div_q <= '0;
        else if (restart_i || tick)         div_q <= '0;
        else                                div_q <= div_q + 1'b1;
      end
      assign tick = (div_q == PW'(PRESCALE - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  // Counter stops at the programmed limit, so no wrap is possible.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i)              cnt_q <= '0;
    else if (tick && cnt_q < tmo_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q >= tmo_i);
endmodule

// File: rtl/cic_trigger.sv
module cic_trigger
  import cic_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [THR_W-1:0] pend_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             tmr_en_i,
  input  logic             expired_i,
  input  logic [MA_W-1:0]  addr_i,
  input  logic [DW-1:0]    data_i,
  input  logic             ack_i,
  output logic             fire_o,
  output logic             req_o,
  output logic [MA_W-1:0]  addr_o,
  output logic [DW-1:0]    data_o
);
  trig_st_e         st_q;
  logic             armed_q;
  logic [THR_W-1:0] snap_q;
  logic [MA_W-1:0]  addr_q;
  logic [DW-1:0]    data_q;
  logic             cnt_hit, tmo_hit, any_pend;

  assign any_pend = (pend_i != '0);
  assign cnt_hit  = (thr_i != '0) && (pend_i >= thr_i);
  assign tmo_hit  = tmr_en_i && expired_i;
  assign fire_o   = (st_q == ST_IDLE) && armed_q && any_pend && (cnt_hit || tmo_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      armed_q <= 1'b1;
      snap_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (fire_o) begin
            st_q    <= ST_REQ;
            armed_q <= 1'b0;
            addr_q  <= addr_i;
            data_q  <= data_i;
          end else if (!armed_q && pend_i != snap_q) begin
            armed_q <= 1'b1;
          end
        end
        ST_REQ: begin
          if (ack_i) begin
            st_q   <= ST_IDLE;
            snap_q <= pend_i;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_o  = (st_q == ST_REQ);
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer
  import cic_pkg::*;
#(
  parameter int unsigned PRESCALE   = 1,
  parameter int unsigned DEF_THR    = 20,
  parameter int unsigned DEF_TMO    = 176,
  parameter bit          DEF_TMR_EN = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_wr_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic [THR_W-1:0] pend_cnt_i,
  input  logic             done_i,
  output logic             msg_req_o,
  input  logic             msg_ack_i,
  output logic [MA_W-1:0]  msg_addr_o,
  output logic [DW-1:0]    msg_data_o
);
  cfg_t cfg;
  logic expired, fire, restart;

  cic_regs #(
    .DEF_THR(DEF_THR), .DEF_TMO(DEF_TMO), .DEF_TMR_EN(DEF_TMR_EN)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(reg_wr_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .cfg_o(cfg)
  );

  assign restart = (pend_cnt_i == '0) || done_i || fire;

  cic_timer #(.PRESCALE(PRESCALE)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .restart_i(restart),
    .tmo_i(cfg.tmo), .expired_o(expired)
  );

  cic_trigger u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend_cnt_i), .thr_i(cfg.thr),
    .tmr_en_i(cfg.tmr_en), .expired_i(expired), .addr_i({cfg.ahi, cfg.alo}),
    .data_i(cfg.data), .ack_i(msg_ack_i), .fire_o(fire), .req_o(msg_req_o),
    .addr_o(msg_addr_o), .data_o(msg_data_o)
  );
endmodule

// File: rtl/cmpl_irq_coalescer_chk.sv
module cmpl_irq_coalescer_chk
  import cic_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [THR_W-1:0] pend_cnt_i,
  input logic             msg_req_o,
  input logic             msg_ack_i,
  input logic [MA_W-1:0]  msg_addr_o,
  input logic [DW-1:0]    msg_data_o
);
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o && !msg_ack_i |=> msg_req_o); // R8
  AST_PAYLOAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o && !msg_ack_i |=> $stable(msg_addr_o) && $stable(msg_data_o)); // R8
  AST_ACK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_o && msg_ack_i |=> !msg_req_o); // R9
  AST_NO_ZERO_PEND_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_req_o) |-> $past(pend_cnt_i) != '0); // R7
endmodule

bind cmpl_irq_coalescer cmpl_irq_coalescer_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pend_cnt_i(pend_cnt_i),
  .msg_req_o(msg_req_o), .msg_ack_i(msg_ack_i),
  .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
);

// File: tb/cmpl_irq_coalescer_tb_top.sv
module cmpl_irq_coalescer_tb_top;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed {
    logic [14:0] thr;
    logic [14:0] pend;
    logic        exp_req;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{15'd20,    15'd19,    1'b0},
    '{15'd20,    15'd20,    1'b1},
    '{15'd20,    15'd21,    1'b1},
    '{15'd1,     15'd1,     1'b1},
    '{15'd0,     15'd100,   1'b0},
    '{15'd32767, 15'd32766, 1'b0},
    '{15'd32767, 15'd32767, 1'b1},
    '{15'd5,     15'd4,     1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [14:0] pend = '0;
  logic        done = 1'b0;
  logic        req;
  logic        ack = 1'b0;
  logic [47:0] maddr;
  logic [31:0] mdata;

  int n_chk = 0;
  int n_err = 0;
  int n_rise = 0;
  logic req_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpl_irq_coalescer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .pend_cnt_i(pend),
    .done_i(done), .msg_req_o(req), .msg_ack_i(ack),
    .msg_addr_o(maddr), .msg_data_o(mdata)
  );

  always @(negedge clk) begin
    if (req && !req_prev) n_rise++;
    req_prev <= req;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
  endtask

  task automatic idle_pend();
    pend = '0;
    tick(2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int rise0;
    tick(2);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(5'h00, r); check("R1 ctrl", 64'(r), 64'h14);
    rd(5'h04, r); check("R1 tmo", 64'(r), 64'hB0);
    check("R1 req", 64'(req), 64'd0);

    // R2 field widths
    wr(5'h00, 32'hFFFF_FFFF); rd(5'h00, r); check("R2 ctrl", 64'(r), 64'h0004_7FFF);
    wr(5'h04, 32'hFFFF_FFFF); rd(5'h04, r); check("R2 tmo", 64'(r), 64'h1FFF);
    wr(5'h0C, 32'hABCD_1234); rd(5'h0C, r); check("R2 ahi", 64'(r), 64'h1234);
    wr(5'h08, 32'h89AB_CDEF); rd(5'h08, r); check("R2 alo", 64'(r), 64'h89AB_CDEF);
    wr(5'h10, 32'hC0FF_EE01); rd(5'h10, r); check("R2 data", 64'(r), 64'hC0FF_EE01);

    // R3 / R4 count threshold vectors, timer off
    for (int i = 0; i < NV; i++) begin
      wr(5'h00, {17'd0, VECS[i].thr});
      idle_pend();
      pend = VECS[i].pend;
      tick(1);
      check(VECS[i].thr == 0 ? "R4 zero threshold" : "R3 threshold",
            64'(req), 64'(VECS[i].exp_req));
      if (req) do_ack();
    end

    // R8 payload capture and hold
    idle_pend();
    wr(5'h00, 32'd2);
    pend = 15'd3;
    tick(1);
    check("R8 req", 64'(req), 64'd1);
    check("R8 addr", 64'(maddr), 64'h1234_89AB_CDEF);
    check("R8 data", 64'(mdata), 64'hC0FF_EE01);
    wr(5'h08, 32'h0000_0001);
    tick(3);
    check("R8 held req", 64'(req), 64'd1);
    check("R8 held addr", 64'(maddr), 64'h1234_89AB_CDEF);
    do_ack();
    check("R9 drop", 64'(req), 64'd0);

    // R9 no refire on unchanged count
    tick(5);
    check("R9 static count", 64'(req), 64'd0);
    pend = 15'd4;
    tick(2);
    check("R9 rearm", 64'(req), 64'd1);
    do_ack();

    // R5 timeout path, count path disabled
    idle_pend();
    wr(5'h00, 32'h0004_0000);
    wr(5'h04, 32'd5);
    idle_pend();
    pend = 15'd1;
    tick(5);
    check("R5 before expiry", 64'(req), 64'd0);
    tick(1);
    check("R5 expiry", 64'(req), 64'd1);
    do_ack();

    // R11 done pulse restarts timer
    idle_pend();
    pend = 15'd1;
    tick(3);
    done = 1'b1;
    tick(1);
    done = 1'b0;
    tick(5);
    check("R11 restarted", 64'(req), 64'd0);
    tick(1);
    check("R11 expiry", 64'(req), 64'd1);
    do_ack();

    // R6 timer disabled
    idle_pend();
    wr(5'h00, 32'h0000_0000);
    pend = 15'd1;
    tick(20);
    check("R6 timer off", 64'(req), 64'd0);

    // R7 zero pending never fires
    pend = '0;
    wr(5'h00, 32'h0004_0000);
    wr(5'h04, 32'd0);
    tick(10);
    check("R7 zero pend", 64'(req), 64'd0);
    pend = 15'd1;
    tick(1);
    check("R7 nonzero pend", 64'(req), 64'd1);
    do_ack();

    // R10 simultaneous count and timeout
    idle_pend();
    wr(5'h00, 32'h0004_0003);
    wr(5'h04, 32'd2);
    idle_pend();
    rise0 = n_rise;
    pend = 15'd2;
    tick(2);
    pend = 15'd3;
    tick(1);
    check("R10 req", 64'(req), 64'd1);
    tick(4);
    do_ack();
    tick(10);
    check("R10 quiet", 64'(req), 64'd0);
    check("R10 single msg", 64'(n_rise - rise0), 64'd1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule